// File: doc/BRIEF.md
# Run-Length Encoding Memory Co-Processor

This block compresses a byte message that sits in a word-wide SRAM and writes the compressed form back into the same SRAM through a single port. Software sets the message byte address, the destination byte address and the message length in bytes, then pulses `start`. The engine fetches 32-bit words, splits them into bytes and finds runs of equal bytes. Each run becomes a pair: a count byte followed by the symbol byte. The pairs are packed into 32-bit words and written out. When the last word is written, the engine raises `done` for one cycle and reports the compressed length in bytes.

Inside, three stages pass data over valid/ready links. A word reader feeds a byte stream. A run finder turns that into a stream of pairs. A word packer consumes the pairs. A stage may hold its ready low at any time. A producer that has raised valid keeps its data unchanged until the transfer happens, so back-pressure never loses or duplicates a byte. The single memory port is shared between reading and writing, and writes take priority. Memory reads have one cycle of latency. A write completes in the cycle it is issued. The source and destination regions must not overlap.

Top module: `rle_engine`

## Requirements
- R1: Every run is written as two bytes: an unsigned 8-bit count first, then the symbol. The pairs follow one another with no gaps, in message order.
- R2: Input words are little-endian. Message byte k is taken from bits 8*(k mod 4)+7 : 8*(k mod 4) of the word at byte address src + 4*floor(k/4).
- R3: Output bytes are packed little-endian into consecutive words starting at the destination address. Each word is written exactly once. Every memory access uses an address whose two low bits are zero.
- R4: When the message length is not a multiple of 4, the bytes of the last input word beyond the length have no effect on the output.
- R5: When the compressed length is not a multiple of 4, the unused upper bytes of the last written word are zero.
- R6: A run longer than 255 bytes is split. The encoder emits count 255, then continues a new run of the same symbol. A count of zero is never emitted.
- R7: `enc_len` equals the number of output bytes, which is twice the number of pairs. A message with no two adjacent equal bytes gives twice its length.
- R8: `done` is high for exactly one cycle, after the last write. `enc_len` is valid from that cycle and holds until the next `start`.
- R9: A message length of zero causes no memory write. It gives `enc_len` = 0 and still produces a `done` pulse.
- R10: While `rst_n` is low, and after its release until a `start`, `done` and `mem_we` are low and `enc_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset to idle |
| start | input | 1 | One-cycle pulse that begins a job when idle |
| src_addr | input | 16 | Byte address of the message (word aligned) |
| dst_addr | input | 16 | Byte address for the compressed output (word aligned) |
| msg_len | input | 32 | Message length in bytes |
| enc_len | output | 32 | Compressed length in bytes |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after the read |

## Verification
The hardest case to reach from the ports is a run that ends on the very last message byte, right after a run boundary caused by the 255 limit or by a symbol change. In that case the run finder has to emit two pairs from a single input byte. The stimulus builds messages of 600 and 256 equal bytes followed by one different byte. It also places odd lengths so that the tail lands in different lanes of a partial word, with garbage in the unused lanes. Every output word is compared against a byte-level encoding done in the bench.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int unsigned SYM_W   = 8;
  localparam int unsigned COUNT_W = 8;
  localparam int unsigned RUN_MAX = (1 << COUNT_W) - 1;

  typedef struct packed {
    logic [SYM_W-1:0]   sym;
    logic [COUNT_W-1:0] cnt;
  } pair_t;
endpackage

// File: rtl/rle_word_reader.sv
module rle_word_reader #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  byte_count,
  output logic              rd_req,
  input  logic              rd_gnt,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [7:0]        b_data,
  output logic              b_last
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  typedef enum logic [1:0] {RD_IDLE, RD_ASK, RD_LATCH, RD_SERVE} rd_state_e;

  rd_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [DATA_W-1:0] word_q;
  logic [IDX_W-1:0]  lane_q;

  assign rd_req  = (state == RD_ASK);
  assign rd_addr = addr_q;
  assign b_valid = (state == RD_SERVE);
  assign b_data  = word_q[8*int'(lane_q) +: 8];
  assign b_last  = (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RD_IDLE;
      addr_q <= '0;
      left_q <= '0;
      word_q <= '0;
      lane_q <= '0;
    end else begin
      case (state)
        RD_IDLE: begin
          if (go && byte_count != '0) begin
            addr_q <= base_addr & ~ADDR_W'(LANES - 1);
            left_q <= byte_count;
            state  <= RD_ASK;
          end
        end
        RD_ASK: begin
          if (rd_gnt) state <= RD_LATCH;
        end
        RD_LATCH: begin
          word_q <= rd_data;
          lane_q <= '0;
          addr_q <= addr_q + ADDR_W'(LANES);
          state  <= RD_SERVE;
        end
        default: begin
          if (b_ready) begin
            left_q <= left_q - LEN_W'(1);
            lane_q <= lane_q + IDX_W'(1);
            if (left_q == LEN_W'(1))                state <= RD_IDLE;
            else if (lane_q == IDX_W'(LANES - 1))   state <= RD_ASK;
          end
        end
      endcase
    end
  end

  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_data) && $stable(b_last))); // R2

  AST_LATCH_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_gnt) |=> (state == RD_LATCH)); // R2
endmodule

// File: rtl/rle_run_finder.sv
module rle_run_finder
  import rle_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       b_valid,
  output logic       b_ready,
  input  logic [7:0] b_data,
  input  logic       b_last,
  output logic       p_valid,
  input  logic       p_ready,
  output pair_t      p_data,
  output logic       p_last
);
  logic               have_q;
  logic [SYM_W-1:0]   sym_q;
  logic [COUNT_W-1:0] cnt_q;
  logic               tail_q;
  logic               pv_q;
  pair_t              pd_q;
  logic               pl_q;
  logic               extend;

  assign b_ready = !pv_q && !tail_q;
  assign p_valid = pv_q;
  assign p_data  = pd_q;
  assign p_last  = pl_q;
  assign extend  = have_q && (b_data == sym_q) && (cnt_q != COUNT_W'(RUN_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      sym_q  <= '0;
      cnt_q  <= '0;
      tail_q <= 1'b0;
      pv_q   <= 1'b0;
      pd_q   <= '0;
      pl_q   <= 1'b0;
    end else if (go) begin
      have_q <= 1'b0;
      tail_q <= 1'b0;
      pv_q   <= 1'b0;
    end else begin
      if (pv_q && p_ready) pv_q <= 1'b0;
      if (tail_q && !pv_q) begin
        pv_q   <= 1'b1;
        pd_q   <= '{sym: sym_q, cnt: cnt_q};
        pl_q   <= 1'b1;
        tail_q <= 1'b0;
        have_q <= 1'b0;
      end else if (b_valid && b_ready) begin
        if (extend) begin
          if (b_last) begin
            pv_q   <= 1'b1;
            pd_q   <= '{sym: sym_q, cnt: cnt_q + COUNT_W'(1)};
            pl_q   <= 1'b1;
            have_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + COUNT_W'(1);
          end
        end else if (have_q) begin
          pv_q   <= 1'b1;
          pd_q   <= '{sym: sym_q, cnt: cnt_q};
          pl_q   <= 1'b0;
          sym_q  <= b_data;
          cnt_q  <= COUNT_W'(1);
          tail_q <= b_last;
        end else if (b_last) begin
          pv_q <= 1'b1;
          pd_q <= '{sym: b_data, cnt: COUNT_W'(1)};
          pl_q <= 1'b1;
        end else begin
          sym_q  <= b_data;
          cnt_q  <= COUNT_W'(1);
          have_q <= 1'b1;
        end
      end
    end
  end

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> (p_data.cnt != '0)); // R6

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n || go)
    (p_valid && !p_ready) |=> (p_valid && $stable(p_data) && $stable(p_last))); // R1
endmodule

// File: rtl/rle_word_packer.sv
module rle_word_packer
  import rle_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              p_valid,
  output logic              p_ready,
  input  pair_t             p_data,
  input  logic              p_last,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              fin,
  output logic [LEN_W-1:0]  out_bytes
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned PAIR_W = SYM_W + COUNT_W;
  localparam int unsigned SLOTS  = DATA_W / PAIR_W;
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOT_W-1:0] slot_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_next;
  logic              pend_q;
  logic              final_q;
  logic              fin_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  nbytes_q;
  logic              slot_full;

  assign p_ready   = !pend_q;
  assign wr_req    = pend_q;
  assign wr_addr   = addr_q;
  assign wr_data   = acc_q;
  assign fin       = fin_q;
  assign out_bytes = nbytes_q;
  assign slot_full = (slot_q == SLOT_W'(SLOTS - 1));

  always_comb begin
    acc_next = (slot_q == '0) ? '0 : acc_q;
    acc_next[PAIR_W*int'(slot_q) +: PAIR_W] = p_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      acc_q    <= '0;
      pend_q   <= 1'b0;
      final_q  <= 1'b0;
      fin_q    <= 1'b0;
      addr_q   <= '0;
      nbytes_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        slot_q   <= '0;
        pend_q   <= 1'b0;
        final_q  <= 1'b0;
        addr_q   <= base_addr & ~ADDR_W'(LANES - 1);
        nbytes_q <= '0;
      end else begin
        if (pend_q) begin
          pend_q <= 1'b0;
          addr_q <= addr_q + ADDR_W'(LANES);
          fin_q  <= final_q;
        end
        if (p_valid && p_ready) begin
          acc_q    <= acc_next;
          nbytes_q <= nbytes_q + LEN_W'(PAIR_W / 8);
          if (slot_full || p_last) begin
            slot_q  <= '0;
            pend_q  <= 1'b1;
            final_q <= p_last;
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
          end
        end
      end
    end
  end

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req); // R3

  AST_FIN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(wr_req)); // R8
endmodule

// File: rtl/rle_engine.sv
module rle_engine
  import rle_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [LEN_W-1:0]  msg_len,
  output logic [LEN_W-1:0]  enc_len,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);

  logic              busy_q;
  logic              empty_done_q;
  logic              go;
  logic              rd_req, rd_gnt;
  logic [ADDR_W-1:0] rd_addr;
  logic              b_valid, b_ready, b_last;
  logic [7:0]        b_data;
  logic              p_valid, p_ready, p_last;
  pair_t             p_data;
  logic              wr_req;
  logic [ADDR_W-1:0] wr_addr;
  logic              fin;

  assign go       = start && !busy_q;
  assign rd_gnt   = rd_req && !wr_req;
  assign mem_we   = wr_req;
  assign mem_addr = wr_req ? wr_addr : rd_addr;
  assign done     = fin || empty_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      empty_done_q <= 1'b0;
    end else begin
      empty_done_q <= go && (msg_len == '0);
      if (go && msg_len != '0) busy_q <= 1'b1;
      else if (fin)            busy_q <= 1'b0;
    end
  end

  rle_word_reader #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_reader (
    .clk, .rst_n, .go,
    .base_addr (src_addr),
    .byte_count(msg_len),
    .rd_req, .rd_gnt, .rd_addr,
    .rd_data   (mem_rdata),
    .b_valid, .b_ready, .b_data, .b_last
  );

  rle_run_finder u_runs (
    .clk, .rst_n, .go,
    .b_valid, .b_ready, .b_data, .b_last,
    .p_valid, .p_ready, .p_data, .p_last
  );

  rle_word_packer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_packer (
    .clk, .rst_n, .go,
    .base_addr(dst_addr),
    .p_valid, .p_ready, .p_data, .p_last,
    .wr_req, .wr_addr,
    .wr_data  (mem_wdata),
    .fin,
    .out_bytes(enc_len)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mem_we); // R9

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || rd_gnt) |-> (mem_addr[OFF_W-1:0] == '0)); // R3

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(enc_len)); // R8
endmodule

// File: tb/tb_rle_engine.sv
module tb_rle_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] src_addr = '0;
  logic [15:0] dst_addr = '0;
  logic [31:0] msg_len = '0;
  logic [31:0] enc_len;
  logic        done;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  logic [31:0] mem [0:4095];
  logic [7:0]  msg [0:1023];
  logic [7:0]  expb [0:2047];
  int          exp_n;
  int          checks = 0;
  int          errors = 0;
  int          writes = 0;
  int          dones = 0;
  int          cyc = 0;

  always #5 clk = ~clk;

  rle_engine dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      mem[mem_addr[13:2]] <= mem_wdata;
      writes <= writes + 1;
    end else begin
      mem_rdata <= mem[mem_addr[13:2]];
    end
    if (done) dones <= dones + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic encode_ref(int len);
    int i = 0;
    exp_n = 0;
    while (i < len) begin
      int c = 1;
      while (i + c < len && msg[i+c] == msg[i] && c < 255) c++;
      expb[exp_n]   = 8'(c);
      expb[exp_n+1] = msg[i];
      exp_n += 2;
      i += c;
    end
  endtask

  task automatic run_job(string tag, int src, int dst, int len);
    int nw = (len + 3) / 4;
    int ow;
    int w0, d0;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] word;
      for (int b = 0; b < 4; b++)
        word[8*b +: 8] = (4*w + b < len) ? msg[4*w+b] : 8'(8'h5A + b);
      mem[src/4 + w] = word;
    end
    for (int w = 0; w < 512; w++) mem[dst/4 + w] = 32'hDEADBEEF;
    encode_ref(len);
    ow = (exp_n + 3) / 4;
    @(negedge clk);
    w0 = writes; d0 = dones;
    src_addr = 16'(src); dst_addr = 16'(dst); msg_len = len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    check({tag, " R8 done seen"}, 32'(done), 32'd1);
    check({tag, " R7 enc_len"}, enc_len, 32'(exp_n));
    check({tag, " R3 write count"}, 32'(writes - w0), 32'(ow));
    for (int w = 0; w < ow; w++) begin
      logic [31:0] e = '0;
      for (int b = 0; b < 4; b++)
        if (4*w + b < exp_n) e[8*b +: 8] = expb[4*w+b];
      check({tag, " R1/R5 output word"}, mem[dst/4 + w], e);
    end
    check({tag, " R3 word after output untouched"}, mem[dst/4 + ow], 32'hDEADBEEF);
    @(negedge clk);
    check({tag, " R8 done one cycle"}, 32'(done), 32'd0);
    check({tag, " R8 single pulse"}, 32'(dones - d0), 32'd1);
    repeat (5) @(negedge clk);
    check({tag, " R8 enc_len held"}, enc_len, 32'(exp_n));
  endtask

  task automatic t_reset();
    check("R10 done in reset", 32'(done), 32'd0);
    check("R10 we in reset", 32'(mem_we), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 done after reset", 32'(done), 32'd0);
    check("R10 we after reset", 32'(mem_we), 32'd0);
    check("R10 enc_len after reset", enc_len, 32'd0);
  endtask

  task automatic t_mixed_runs();
    int n = 0;
    int lens [7] = '{12, 1, 12, 3, 24, 1, 14};
    for (int r = 0; r < 7; r++)
      for (int k = 0; k < lens[r]; k++) begin msg[n] = (r % 2 == 0) ? 8'h57 : 8'h42; n++; end
    run_job("mixed R1 R2", 'h100, 'h2000, n);
  endtask

  task automatic t_distinct();
    for (int i = 0; i < 5; i++) msg[i] = 8'(8'h10 + i);
    run_job("distinct5 R4 R5 R7", 'h100, 'h2000, 5);
    for (int i = 0; i < 8; i++) msg[i] = 8'(i * 3);
    run_job("distinct8 R7", 'h104, 'h2010, 8);
    msg[0] = 8'h00; msg[1] = 8'h00; msg[2] = 8'h00;
    run_job("tail3 R4", 'h100, 'h2000, 3);
  endtask

  task automatic t_long_runs();
    for (int i = 0; i < 600; i++) msg[i] = 8'h41;
    msg[600] = 8'h42;
    run_job("run600 R6", 'h100, 'h2000, 601);
    for (int i = 0; i < 256; i++) msg[i] = 8'h7E;
    run_job("run256 R6", 'h100, 'h2000, 256);
    for (int i = 0; i < 255; i++) msg[i] = 8'hC3;
    msg[255] = 8'hC3; msg[256] = 8'h01;
    run_job("run255 tail R6", 'h100, 'h2000, 257);
  endtask

  task automatic t_empty();
    int w0, d0;
    @(negedge clk);
    w0 = writes; d0 = dones;
    msg_len = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 20 && !done; t++) @(negedge clk);
    check("R9 done for empty", 32'(done), 32'd1);
    check("R9 enc_len zero", enc_len, 32'd0);
    repeat (4) @(negedge clk);
    check("R9 no writes", 32'(writes - w0), 32'd0);
    check("R9 one done", 32'(dones - d0), 32'd1);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_mixed_runs();
    t_distinct();
    t_long_runs();
    t_empty();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule